// File: doc/BRIEF.md
# Low-Power Clock Halt and Wake Controller

This block decides, one raw-oscillator cycle at a time, whether the processor core receives its internal clock. A stop strobe freezes the core clock at logic high and switches the main oscillator off. A wait strobe freezes only the core clock and leaves the oscillator running. Leaving wait is immediate. Leaving stop is paced by an oscillation-settling countdown so that the core never sees a clock from an oscillator that has not yet stabilised.

The countdown is a chain of three stages. A divide-by-16 stage runs from the raw clock. It feeds an 8-bit prescaler, which feeds an 8-bit timer. The core clock comes back only when the timer underflows. When the settle-mode input is 0, stop entry presets the timer to 0x01 and the prescaler to 0xFF. When it is 1, both stages keep the values software last wrote. A wake interrupt counts only if its enable was set when the halt began. Reset always ends a halt at once, with no settling wait. A stop strobe is ignored while the core is clocked from the ring oscillator.

States and transitions, one per raw clock edge:
- RUN: the clock runs and the oscillator is on.
- RUN→STOP_OFF: a stop strobe arrives and the ring flag is low.
- RUN→WAIT: a wait strobe arrives and no stop is taken.
- STOP_OFF→STOP_SETTLE: an armed interrupt arrives.
- STOP_SETTLE→RUN: the timer underflows.
- WAIT→RUN: an armed interrupt arrives.
- Any state→RUN: reset.

Top module: `clk_halt_ctrl`

## Requirements
- R1: Directly after reset, `cpu_clk_en_o`=1, `osc_en_o`=1 and `tmr_uf_o`=0.
- R2: A stop strobe sampled in RUN with `ring_active_i`=0 makes `cpu_clk_en_o`=0 and `osc_en_o`=0 from the next cycle, and `cpu_clk_o` is then held at 1.
- R3: With `stab_keep_i`=0 at stop entry, the timer is preset to 0x01 and the prescaler to 0xFF, overriding any written values. The settling phase then lasts exactly 16*256*2 = 8192 raw cycles.
- R4: With `stab_keep_i`=1 at stop entry, the written values P (prescaler) and T (timer) are kept. The settling phase lasts exactly 16*(P+1)*(T+1) raw cycles.
- R5: The divide-by-16 stage is cleared on stop entry. With P=0 and T=0, the settling phase is exactly 16 raw cycles.
- R6: An armed interrupt in STOP_OFF sets `osc_en_o`=1 on the next cycle. `cpu_clk_en_o` stays 0 until the timer underflows. In the cycle the clock resumes, `tmr_uf_o` is 1 for exactly one cycle.
- R7: An interrupt whose enable `irq_en_i` was 0 at halt entry wakes neither stop nor wait, even if the enable rises later.
- R8: A stop strobe has no effect while `ring_active_i`=1: the clock and the oscillator stay on.
- R9: A wait strobe makes `cpu_clk_en_o`=0 from the next cycle while `osc_en_o` stays 1. An armed interrupt restores `cpu_clk_en_o`=1 on the following cycle.
- R10: Asserting reset during STOP_OFF, STOP_SETTLE or WAIT sets `cpu_clk_en_o`=1 and `osc_en_o`=1 at once, with no settling wait.
- R11: When stop and wait strobes arrive together, stop wins, unless `ring_active_i`=1, in which case wait is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | Stop strobe |
| wait_req_i | input | 1 | Wait strobe |
| irq_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Enable bit of the wake interrupt |
| stab_keep_i | input | 1 | 1 keeps the written countdown values on stop entry |
| ring_active_i | input | 1 | Core is running from the ring oscillator |
| pre_wr_i | input | 1 | Write strobe for the prescaler value |
| pre_wr_data_i | input | 8 | Prescaler value to write |
| tmr_wr_i | input | 1 | Write strobe for the timer value |
| tmr_wr_data_i | input | 8 | Timer value to write |
| cpu_clk_o | output | 1 | Gated core clock, held high while halted |
| cpu_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| tmr_uf_o | output | 1 | One-cycle pulse when the timer underflows |

## Verification
The bench builds the block with its default parameters: 8-bit prescaler, 8-bit timer and a divide-by-16 stage. With these defaults the full preset wait of 8192 cycles is short enough to count edge by edge. Written values of zero bring the shortest possible 16-cycle settle within reach, which isolates the divide stage. A 3-by-2 case checks that the prescaler and timer periods multiply. Masked wakes, the ring-oscillator block, simultaneous strobes and reset in every halt state are each driven as separate scenarios.

// File: rtl/clk_halt_pkg.sv
package clk_halt_pkg;
    typedef enum logic [1:0] {
        ST_RUN          = 2'd0,
        ST_STOP_OFF     = 2'd1,
        ST_STOP_SETTLE  = 2'd2,
        ST_WAIT         = 2'd3
    } halt_state_e;
endpackage

// File: rtl/clk_halt_div.sv
module clk_halt_div #(
    parameter int DIV = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

    AST_DIV_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/clk_halt_dcnt.sv
module clk_halt_dcnt #(
    parameter int W      = 8,
    parameter int PRESET = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         preset_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         tick_i,
    output logic         uf_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] INIT = W'(PRESET);

    logic [W-1:0] cnt_q;
    logic [W-1:0] rld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= INIT;
            rld_q <= INIT;
        end else if (preset_i) begin
            cnt_q <= INIT;
            rld_q <= INIT;
        end else if (wr_i) begin
            cnt_q <= wr_data_i;
            rld_q <= wr_data_i;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
        end
    end

    assign uf_o  = tick_i && (cnt_q == '0);
    assign cnt_o = cnt_q;

    AST_RELOAD_ON_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uf_o && !preset_i && !wr_i) |=> (cnt_q == $past(rld_q))); // R4
endmodule

// File: rtl/clk_halt_ctrl.sv
module clk_halt_ctrl
    import clk_halt_pkg::*;
#(
    parameter int PRE_W   = 8,
    parameter int TMR_W   = 8,
    parameter int OSC_DIV = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_req_i,
    input  logic             wait_req_i,
    input  logic             irq_i,
    input  logic             irq_en_i,
    input  logic             stab_keep_i,
    input  logic             ring_active_i,
    input  logic             pre_wr_i,
    input  logic [PRE_W-1:0] pre_wr_data_i,
    input  logic             tmr_wr_i,
    input  logic [TMR_W-1:0] tmr_wr_data_i,
    output logic             cpu_clk_o,
    output logic             cpu_clk_en_o,
    output logic             osc_en_o,
    output logic             tmr_uf_o
);
    localparam int PRE_PRESET = (1 << PRE_W) - 1;
    localparam int TMR_PRESET = 1;

    halt_state_e state_q, state_d;
    logic        armed_q;
    logic        uf_q;

    logic stop_go, wait_go, wake;
    logic settling, div_tick, pre_uf, tmr_uf, preset_now;
    logic [PRE_W-1:0] pre_cnt;
    logic [TMR_W-1:0] tmr_cnt;

    assign stop_go    = (state_q == ST_RUN) && stop_req_i && !ring_active_i;
    assign wait_go    = (state_q == ST_RUN) && wait_req_i && !stop_go;
    assign wake       = irq_i && armed_q;
    assign settling   = (state_q == ST_STOP_SETTLE);
    assign preset_now = stop_go && !stab_keep_i;

    clk_halt_div #(.DIV(OSC_DIV)) div_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (stop_go),
        .en_i   (settling),
        .tick_o (div_tick)
    );

    clk_halt_dcnt #(.W(PRE_W), .PRESET(PRE_PRESET)) pre_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .preset_i  (preset_now),
        .wr_i      (pre_wr_i),
        .wr_data_i (pre_wr_data_i),
        .tick_i    (div_tick),
        .uf_o      (pre_uf),
        .cnt_o     (pre_cnt)
    );

    clk_halt_dcnt #(.W(TMR_W), .PRESET(TMR_PRESET)) tmr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .preset_i  (preset_now),
        .wr_i      (tmr_wr_i),
        .wr_data_i (tmr_wr_data_i),
        .tick_i    (pre_uf),
        .uf_o      (tmr_uf),
        .cnt_o     (tmr_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_go)      state_d = ST_STOP_OFF;
                else if (wait_go) state_d = ST_WAIT;
            end
            ST_STOP_OFF:    if (wake)   state_d = ST_STOP_SETTLE;
            ST_STOP_SETTLE: if (tmr_uf) state_d = ST_RUN;
            ST_WAIT:        if (wake)   state_d = ST_RUN;
            default:                    state_d = ST_RUN;
        endcase
    end

    // state register; all changes follow a rising raw edge, while clk_i is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            armed_q <= 1'b0;
            uf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            uf_q    <= settling && tmr_uf;
            if (stop_go || wait_go) armed_q <= irq_en_i;
        end
    end

    // outputs
    always_comb begin
        cpu_clk_en_o = 1'b0;
        osc_en_o     = 1'b1;
        unique case (state_q)
            ST_RUN:         cpu_clk_en_o = 1'b1;
            ST_STOP_OFF:    osc_en_o     = 1'b0;
            ST_STOP_SETTLE: osc_en_o     = 1'b1;
            ST_WAIT:        osc_en_o     = 1'b1;
            default:        cpu_clk_en_o = 1'b1;
        endcase
    end

    assign tmr_uf_o  = uf_q;
    assign cpu_clk_o = clk_i | ~cpu_clk_en_o;

    AST_STOP_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_go |=> (!cpu_clk_en_o && !osc_en_o)); // R2
    AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preset_now |=> (tmr_cnt == TMR_W'(TMR_PRESET) && pre_cnt == PRE_W'(PRE_PRESET))); // R3
    AST_HOLD_UNTIL_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settling && !tmr_uf) |=> (!cpu_clk_en_o && osc_en_o)); // R6
    AST_RING_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_RUN) && stop_req_i && ring_active_i) |=> osc_en_o); // R8
    AST_WAIT_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_WAIT) && irq_i && armed_q) |=> cpu_clk_en_o); // R9
    AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_STOP_OFF) && !armed_q) |=> !osc_en_o); // R7
endmodule

// File: tb/clk_halt_ctrl_tb.sv
`timescale 1ns/1ps
module clk_halt_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, wait_req = 0, irq = 0, irq_en = 0, keep = 0, ring = 0;
    logic pre_wr = 0, tmr_wr = 0;
    logic [7:0] pre_d = 0, tmr_d = 0;
    logic cpu_clk, clk_en, osc_en, uf;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk_halt_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .wait_req_i(wait_req),
        .irq_i(irq), .irq_en_i(irq_en), .stab_keep_i(keep), .ring_active_i(ring),
        .pre_wr_i(pre_wr), .pre_wr_data_i(pre_d), .tmr_wr_i(tmr_wr), .tmr_wr_data_i(tmr_d),
        .cpu_clk_o(cpu_clk), .cpu_clk_en_o(clk_en), .osc_en_o(osc_en), .tmr_uf_o(uf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        stop_req = 0; wait_req = 0; irq = 0; irq_en = 0; keep = 0; ring = 0;
        pre_wr = 0; tmr_wr = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic write_vals(input int p, input int t);
        pre_d = 8'(p); tmr_d = 8'(t); pre_wr = 1; tmr_wr = 1;
        @(negedge clk);
        pre_wr = 0; tmr_wr = 0;
    endtask

    // enter stop, wake with an armed irq, count settle cycles
    task automatic stop_and_settle(input bit keep_v, output int n, output int uf_at, output int uf_after);
        keep = keep_v; irq_en = 1; stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        irq = 1;
        @(negedge clk);
        irq = 0;
        n = 0;
        while (!clk_en && osc_en && n < 20000) begin
            n++;
            @(negedge clk);
        end
        uf_at = uf;
        @(negedge clk);
        uf_after = uf;
    endtask

    task automatic t_reset_state();
        chk("R1 clk_en", clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 uf", uf, 0);
    endtask

    task automatic t_stop_entry();
        irq_en = 1; stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        chk("R2 clk_en", clk_en, 0);
        chk("R2 osc_en", osc_en, 0);
        chk("R2 cpu_clk held high", cpu_clk, 1);
        irq = 1;
        @(negedge clk);
        irq = 0;
        chk("R6 osc_en after irq", osc_en, 1);
        chk("R6 clk_en still off", clk_en, 0);
        do_reset();
    endtask

    task automatic t_preset();
        int n, a, b;
        write_vals(3, 5);
        stop_and_settle(1'b0, n, a, b);
        chk("R3 settle cycles", n, 8192);
        chk("R6 uf pulse", a, 1);
        chk("R6 uf one cycle", b, 0);
        chk("R6 clock resumed", clk_en, 1);
    endtask

    task automatic t_keep();
        int n, a, b;
        write_vals(2, 1);
        stop_and_settle(1'b1, n, a, b);
        chk("R4 settle cycles P=2 T=1", n, 96);
        stop_and_settle(1'b1, n, a, b);
        chk("R4 reloaded settle cycles", n, 96);
        write_vals(0, 0);
        stop_and_settle(1'b1, n, a, b);
        chk("R5 settle cycles P=0 T=0", n, 16);
        chk("R6 uf pulse short", a, 1);
    endtask

    task automatic t_masked();
        irq_en = 0; stop_req = 1;
        @(negedge clk);
        stop_req = 0; irq_en = 1; irq = 1;
        repeat (5) @(negedge clk);
        chk("R7 stop masked osc", osc_en, 0);
        chk("R7 stop masked clk", clk_en, 0);
        irq = 0;
        rst_n = 0;
        #1;
        chk("R10 reset from stop clk", clk_en, 1);
        chk("R10 reset from stop osc", osc_en, 1);
        do_reset();
        irq_en = 0; wait_req = 1;
        @(negedge clk);
        wait_req = 0; irq_en = 1; irq = 1;
        repeat (5) @(negedge clk);
        chk("R7 wait masked clk", clk_en, 0);
        do_reset();
    endtask

    task automatic t_ring();
        ring = 1; stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        chk("R8 clk_en", clk_en, 1);
        chk("R8 osc_en", osc_en, 1);
        @(negedge clk);
        ring = 0;
    endtask

    task automatic t_wait();
        irq_en = 1; wait_req = 1;
        @(negedge clk);
        wait_req = 0;
        chk("R9 wait clk_en", clk_en, 0);
        chk("R9 wait osc_en", osc_en, 1);
        @(negedge clk);
        irq = 1;
        @(negedge clk);
        irq = 0;
        chk("R9 wake clk_en", clk_en, 1);
        irq_en = 1; wait_req = 1;
        @(negedge clk);
        wait_req = 0;
        rst_n = 0;
        #1;
        chk("R10 reset from wait", clk_en, 1);
        do_reset();
    endtask

    task automatic t_settle_reset();
        write_vals(0, 5);
        keep = 1; irq_en = 1; stop_req = 1;
        @(negedge clk);
        stop_req = 0; irq = 1;
        @(negedge clk);
        irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        #1;
        chk("R10 reset from settle clk", clk_en, 1);
        chk("R10 reset from settle osc", osc_en, 1);
        do_reset();
    endtask

    task automatic t_both();
        irq_en = 1; stop_req = 1; wait_req = 1;
        @(negedge clk);
        stop_req = 0; wait_req = 0;
        chk("R11 stop wins osc", osc_en, 0);
        do_reset();
        ring = 1; stop_req = 1; wait_req = 1;
        @(negedge clk);
        stop_req = 0; wait_req = 0;
        chk("R11 ring gives wait clk", clk_en, 0);
        chk("R11 ring gives wait osc", osc_en, 1);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_stop_entry();
        t_preset();
        t_keep();
        t_masked();
        t_ring();
        t_wait();
        t_settle_reset();
        t_both();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule